// File: doc/BRIEF.md
# Output Driver Impedance Step Adjuster

This block keeps two small step counters that set the strength of an output driver: one for the pull-up half and one for the pull-down half. A 3-bit calibration mode value, written through a mode-write strobe, selects what the block does. Two drive modes hold the driver at a fixed level, and an adjust mode turns the write data path into a command channel. In adjust mode, each group of four beat strobes carries one bit per beat. These four bits form a code that moves one or both counters by one step. Each counter stops at its upper and lower limit and does not wrap.

A default mode loads a parameterized step into both counters. The block then locks and accepts only the exit mode before it takes any other mode write. Codes with no defined meaning leave the counters alone and raise a one-cycle flag.

The controller has five states. ST_NORMAL is calibration off. ST_DRIVE_HI and ST_DRIVE_LO are the two drive modes. ST_ADJUST collects beats. ST_DFLT_HOLD waits for the exit after a default load. The transitions are as follows:
- From any state except ST_DFLT_HOLD, a mode write moves to the state named by the mode value: 000 to ST_NORMAL, 001 to ST_DRIVE_HI, 010 to ST_DRIVE_LO, 100 to ST_ADJUST, 111 to ST_DFLT_HOLD.
- From ST_DFLT_HOLD, only a write of 000 leaves, and it goes to ST_NORMAL.
- Mode values 011, 101 and 110 cause no transition.

Top module: `drv_imp_trim`

## Requirements
- R1: After reset both step outputs equal the DFLT_STEP parameter (default 8), the reserved flag is 0 and the block is in ST_NORMAL.
- R2: A mode write of 000, 001, 010, 100 or 111 moves the block to ST_NORMAL, ST_DRIVE_HI, ST_DRIVE_LO, ST_ADJUST or ST_DFLT_HOLD respectively. A write of 011, 101 or 110 changes neither the state nor the counters.
- R3: In ST_ADJUST, four beat strobes form a 4-bit code with the first beat as the most significant bit. The code takes effect at the clock edge that samples the fourth beat. A mode write in the same cycle as a beat takes priority and the beat is dropped.
- R4: Code bits [1:0] drive the pull-up counter: 01 adds one step, 10 removes one step, 00 leaves it unchanged.
- R5: Code bits [3:2] drive the pull-down counter: 01 adds one step, 10 removes one step, 00 leaves it unchanged.
- R6: Codes 0101, 0110, 1001 and 1010 move both counters in the same update.
- R7: A code in which either 2-bit field is 11 is reserved. It leaves both counters unchanged and sets code_rsvd for exactly one cycle.
- R8: Each counter saturates. It stays at 15 when asked to rise and at 0 when asked to fall, and it never moves by more than one step per update.
- R9: A mode write of 111 loads DFLT_STEP into both counters.
- R10: In ST_DFLT_HOLD, every mode write other than 000 is ignored and all beats are ignored.
- R11: A mode write during a partly collected burst discards the collected beats. In ST_ADJUST, bursts may follow one another without any new mode write.
- R12: Beat strobes outside ST_ADJUST do not change the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Strobe: mode_val is valid this cycle |
| mode_val | input | 3 | Calibration mode value |
| beat_stb | input | 1 | One data beat is present this cycle |
| beat_bit | input | 1 | Data bit carried by the beat |
| pu_step | output | 4 | Pull-up strength step |
| pd_step | output | 4 | Pull-down strength step |
| code_rsvd | output | 1 | One-cycle pulse for a reserved code |

## Verification
The hardest conditions to reach from the ports are the saturation limits and the partial-burst discard.

To reach the limits, the stimulus issues long runs of complete "both up" and "both down" bursts, so each counter hits its ceiling and its floor and then receives further requests there. To exercise the discard, the stimulus sends a half burst, interrupts it with a new adjust-mode write, and sends a full burst; any leftover beat would shift the resulting code.

The hold state after a default load is probed in two ways. Beats and non-exit mode writes are sent while the block is held, and an adjust burst is sent only after the exit write.

// File: rtl/dit_pkg.sv
package dit_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_DRIVE_HI,
        ST_DRIVE_LO,
        ST_ADJUST,
        ST_DFLT_HOLD
    } trim_state_e;

    localparam logic [2:0] MODE_EXIT    = 3'b000;
    localparam logic [2:0] MODE_DRV_HI  = 3'b001;
    localparam logic [2:0] MODE_DRV_LO  = 3'b010;
    localparam logic [2:0] MODE_ADJUST  = 3'b100;
    localparam logic [2:0] MODE_DEFAULT = 3'b111;

    typedef struct packed {
        logic up;
        logic dn;
    } step_cmd_t;
endpackage

// File: rtl/dit_code_dec.sv
module dit_code_dec
    import dit_pkg::*;
#(
    parameter int NCTR = 2
) (
    input  logic [2*NCTR-1:0]          code,
    output step_cmd_t [NCTR-1:0]       cmd,
    output logic                       rsvd
);
    logic [NCTR-1:0] bad;

    // one 2-bit field per counter: 01 up, 10 down, 00 hold, 11 reserved
    for (genvar k = 0; k < NCTR; k++) begin : g_field
        logic [1:0] fld;
        assign fld       = code[2*k +: 2];
        assign cmd[k].up = (fld == 2'b01);
        assign cmd[k].dn = (fld == 2'b10);
        assign bad[k]    = (fld == 2'b11);
    end

    assign rsvd = |bad;
endmodule

// File: rtl/dit_sat_ctr.sv
module dit_sat_ctr #(
    parameter int W    = 4,
    parameter int DFLT = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP  = '1;
    localparam logic [W-1:0] BOT  = '0;
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] INIT = W'(DFLT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (load) begin
            q <= INIT;
        end else if (inc && !dec && q != TOP) begin
            q <= q + ONE;
        end else if (dec && !inc && q != BOT) begin
            q <= q - ONE;
        end
    end
endmodule

// File: rtl/drv_imp_trim.sv
module drv_imp_trim
    import dit_pkg::*;
#(
    parameter int STEP_W    = 4,
    parameter int DFLT_STEP = 8,
    parameter int BEATS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [2:0]        mode_val,
    input  logic              beat_stb,
    input  logic              beat_bit,
    output logic [STEP_W-1:0] pu_step,
    output logic [STEP_W-1:0] pd_step,
    output logic              code_rsvd
);
    localparam int NCTR  = BEATS / 2;
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);
    localparam logic [CNT_W-1:0] C1   = CNT_W'(1);

    trim_state_e state, nxt, mode_tgt;
    logic [CNT_W-1:0] beat_cnt;
    logic [BEATS-1:0] shreg, code_nx;
    step_cmd_t [NCTR-1:0] cmd;
    logic rsvd, apply, dflt_load;
    logic [NCTR-1:0][STEP_W-1:0] steps;

    assign code_nx   = {shreg[BEATS-2:0], beat_bit};
    assign apply     = (state == ST_ADJUST) && !mode_wr && beat_stb && (beat_cnt == LAST);
    assign dflt_load = mode_wr && (mode_val == MODE_DEFAULT) && (state != ST_DFLT_HOLD);

    always_comb begin
        unique case (mode_val)
            MODE_EXIT:    mode_tgt = ST_NORMAL;
            MODE_DRV_HI:  mode_tgt = ST_DRIVE_HI;
            MODE_DRV_LO:  mode_tgt = ST_DRIVE_LO;
            MODE_ADJUST:  mode_tgt = ST_ADJUST;
            MODE_DEFAULT: mode_tgt = ST_DFLT_HOLD;
            default:      mode_tgt = state;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_NORMAL, ST_DRIVE_HI, ST_DRIVE_LO, ST_ADJUST:
                if (mode_wr) nxt = mode_tgt;
            ST_DFLT_HOLD:
                if (mode_wr && mode_val == MODE_EXIT) nxt = ST_NORMAL;
            default: nxt = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_NORMAL;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt  <= '0;
            shreg     <= '0;
            code_rsvd <= 1'b0;
        end else begin
            code_rsvd <= apply && rsvd;
            if (mode_wr) begin
                beat_cnt <= '0;
                shreg    <= '0;
            end else if (beat_stb && state == ST_ADJUST) begin
                beat_cnt <= (beat_cnt == LAST) ? '0 : beat_cnt + C1;
                shreg    <= (beat_cnt == LAST) ? '0 : code_nx;
            end
        end
    end

    dit_code_dec #(.NCTR(NCTR)) u_dec (
        .code (code_nx),
        .cmd  (cmd),
        .rsvd (rsvd)
    );

    for (genvar k = 0; k < NCTR; k++) begin : g_ctr
        dit_sat_ctr #(.W(STEP_W), .DFLT(DFLT_STEP)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (dflt_load),
            .inc   (apply && !rsvd && cmd[k].up),
            .dec   (apply && !rsvd && cmd[k].dn),
            .q     (steps[k])
        );
    end

    assign pu_step = steps[0];
    assign pd_step = steps[NCTR-1];
endmodule

// File: rtl/drv_imp_trim_chk.sv
module drv_imp_trim_chk #(
    parameter int STEP_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_wr,
    input logic [2:0]        mode_val,
    input logic              beat_stb,
    input logic [STEP_W-1:0] pu_step,
    input logic [STEP_W-1:0] pd_step,
    input logic              code_rsvd
);
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_stb && !(mode_wr && mode_val == 3'b111)) |=> ($stable(pu_step) && $stable(pd_step))); // R12

    AST_PU_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_wr && mode_val == 3'b111) |=>
        ((pu_step == $past(pu_step)) ||
         ({1'b0, pu_step} == {1'b0, $past(pu_step)} + 1'b1) ||
         ({1'b0, pu_step} + 1'b1 == {1'b0, $past(pu_step)}))); // R8

    AST_PD_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_wr && mode_val == 3'b111) |=>
        ((pd_step == $past(pd_step)) ||
         ({1'b0, pd_step} == {1'b0, $past(pd_step)} + 1'b1) ||
         ({1'b0, pd_step} + 1'b1 == {1'b0, $past(pd_step)}))); // R8

    AST_RSVD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        code_rsvd |=> !code_rsvd); // R7

    AST_RSVD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        code_rsvd |-> ($stable(pu_step) && $stable(pd_step))); // R7

    AST_RSVD_FROM_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        code_rsvd |-> $past(beat_stb)); // R3
endmodule

bind drv_imp_trim drv_imp_trim_chk #(.STEP_W(STEP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .mode_val  (mode_val),
    .beat_stb  (beat_stb),
    .pu_step   (pu_step),
    .pd_step   (pd_step),
    .code_rsvd (code_rsvd)
);

// File: tb/sim_drv_imp_trim.sv
module sim_drv_imp_trim;
    localparam int STEP_W = 4;
    localparam int DFLT   = 8;
    localparam int TOPV   = (1 << STEP_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr = 1'b0;
    logic [2:0] mode_val = 3'b000;
    logic beat_stb = 1'b0;
    logic beat_bit = 1'b0;
    logic [STEP_W-1:0] pu_step, pd_step;
    logic code_rsvd;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit started = 0;

    // behavioural reference: 0 normal,1 drive hi,2 drive lo,3 adjust,4 hold
    int m_st, m_cnt, m_code, m_pu, m_pd, m_err;

    always #5 clk = ~clk;

    drv_imp_trim #(.STEP_W(STEP_W), .DFLT_STEP(DFLT), .BEATS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
        .beat_stb(beat_stb), .beat_bit(beat_bit),
        .pu_step(pu_step), .pd_step(pd_step), .code_rsvd(code_rsvd)
    );

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_code = 0; m_pu = DFLT; m_pd = DFLT; m_err = 0;
        end else begin
            m_err = 0;
            if (mode_wr) begin
                m_cnt = 0; m_code = 0;
                if (m_st == 4) begin
                    if (mode_val == 3'b000) m_st = 0;
                end else begin
                    case (mode_val)
                        3'b000: m_st = 0;
                        3'b001: m_st = 1;
                        3'b010: m_st = 2;
                        3'b100: m_st = 3;
                        3'b111: begin m_st = 4; m_pu = DFLT; m_pd = DFLT; end
                        default: ;
                    endcase
                end
            end else if (beat_stb && m_st == 3) begin
                m_code = m_code * 2 + int'(beat_bit);
                m_cnt++;
                if (m_cnt == 4) begin
                    int pf, df;
                    pf = m_code % 4;
                    df = m_code / 4;
                    if (pf == 3 || df == 3) m_err = 1;
                    else begin
                        if (pf == 1 && m_pu < TOPV) m_pu++;
                        if (pf == 2 && m_pu > 0) m_pu--;
                        if (df == 1 && m_pd < TOPV) m_pd++;
                        if (df == 2 && m_pd > 0) m_pd--;
                    end
                    m_cnt = 0; m_code = 0;
                end
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check(cur_req, "pu_step vs model", int'(pu_step), m_pu);
            check(cur_req, "pd_step vs model", int'(pd_step), m_pd);
            check(cur_req, "code_rsvd vs model", int'(code_rsvd), m_err);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        mode_wr = 1'b0; beat_stb = 1'b0;
    endtask

    task automatic mode_write(logic [2:0] v);
        @(posedge clk); #1;
        beat_stb = 1'b0; mode_wr = 1'b1; mode_val = v;
        tick();
    endtask

    task automatic beats(logic [3:0] code, int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            mode_wr = 1'b0; beat_stb = 1'b1; beat_bit = code[3 - i];
        end
        tick();
    endtask

    task automatic burst(logic [3:0] code);
        beats(code, 4);
    endtask

    initial begin
        #1500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_req = "R1";
        check("R1", "pu reset", int'(pu_step), DFLT);
        check("R1", "pd reset", int'(pd_step), DFLT);
        check("R1", "flag reset", int'(code_rsvd), 0);

        cur_req = "R12";
        mode_write(3'b001); burst(4'b0001);
        mode_write(3'b010); burst(4'b0100);
        check("R12", "pu after drive beats", int'(pu_step), DFLT);
        check("R12", "pd after drive beats", int'(pd_step), DFLT);

        cur_req = "R4";
        mode_write(3'b100);
        burst(4'b0001); check("R4", "pu up", int'(pu_step), 9);
        burst(4'b0010); check("R4", "pu down", int'(pu_step), 8);
        cur_req = "R5";
        burst(4'b0100); check("R5", "pd up", int'(pd_step), 9);
        burst(4'b1000); check("R5", "pd down", int'(pd_step), 8);
        cur_req = "R6";
        burst(4'b0101); check("R6", "both up pu", int'(pu_step), 9);
        burst(4'b0110); check("R6", "pu down pd up", int'(pd_step), 10);
        burst(4'b1001); check("R6", "pu up pd down", int'(pu_step), 9);
        burst(4'b1010); check("R6", "both down pd", int'(pd_step), 8);
        burst(4'b0000); check("R4", "no-op pu", int'(pu_step), 8);

        cur_req = "R7";
        burst(4'b0011);
        check("R7", "flag on reserved", int'(code_rsvd), 1);
        check("R7", "pu frozen", int'(pu_step), 8);
        tick();
        check("R7", "flag one cycle", int'(code_rsvd), 0);
        burst(4'b1100); check("R7", "pd frozen", int'(pd_step), 8);

        cur_req = "R8";
        for (int i = 0; i < 10; i++) burst(4'b0101);
        check("R8", "pu ceiling", int'(pu_step), TOPV);
        check("R8", "pd ceiling", int'(pd_step), TOPV);
        for (int i = 0; i < 20; i++) burst(4'b1010);
        check("R8", "pu floor", int'(pu_step), 0);
        check("R8", "pd floor", int'(pd_step), 0);

        cur_req = "R11";
        beats(4'b1100, 2);
        mode_write(3'b100);
        burst(4'b0001);
        check("R11", "pu after discard", int'(pu_step), 1);
        check("R11", "pd after discard", int'(pd_step), 0);

        cur_req = "R2";
        mode_write(3'b011);
        burst(4'b0001);
        check("R2", "reserved mode ignored", int'(pu_step), 2);

        cur_req = "R9";
        mode_write(3'b111);
        check("R9", "pu default", int'(pu_step), DFLT);
        check("R9", "pd default", int'(pd_step), DFLT);

        cur_req = "R10";
        mode_write(3'b100); burst(4'b0001);
        mode_write(3'b001); burst(4'b0100);
        check("R10", "pu held", int'(pu_step), DFLT);
        check("R10", "pd held", int'(pd_step), DFLT);

        cur_req = "R3";
        mode_write(3'b000);
        mode_write(3'b100);
        burst(4'b1001);
        check("R3", "pu after exit", int'(pu_step), DFLT + 1);
        check("R3", "pd after exit", int'(pd_step), DFLT - 1);

        repeat (3) tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule